// File: doc/BRIEF.md
# Region Write-Protected Byte RAM

This block is a synchronous single-port byte memory for an 8-bit processor bus. The address space is cut into equal regions. Each region owns one bit of a write-enable mask. A store to a region whose bit is clear never reaches the array. Instead it raises a sticky fault output that system logic can use to halt or shut down cleanly after a runaway program.

The mask itself sits behind a separate register-select input. It can only be loaded while a privilege input, driven from a status flag exported by the processor, is high. A privileged load of the mask also clears the fault. A build-time parameter removes protection altogether: every write then lands and the fault output stays low.

Reads are never gated. Read data, from the array or from the mask, appears one clock after the address.

Top module: `wpram_top`

## Requirements
- R1: After reset the mask is all ones, which reads back as 0xFF with `reg_sel`=1, and `wr_fault` is 0.
- R2: With `reg_sel`=0, `rd_data` shows the byte at `addr` one clock edge after `addr` is presented.
- R3: The region of an access is `addr[9:7]`, giving eight regions of 128 bytes. Region n is writable only while mask bit n is 1. For example, 0x07F is in region 0 and 0x080 is in region 1.
- R4: A write with `reg_sel`=0 to a region whose mask bit is 0 leaves the array unchanged and sets `wr_fault` at the next clock edge.
- R5: `wr_fault` stays set until reset, or until a mask write made with `priv`=1, which clears it at that clock edge.
- R6: A write with `reg_sel`=1 while `priv`=0 has no effect on the mask or on `wr_fault`.
- R7: A write with `reg_sel`=1 while `priv`=1 loads `wr_data` into the mask. A read with `reg_sel`=1 returns the mask in `rd_data` one edge later.
- R8: When a read and a write hit the same address in the same cycle, `rd_data` shows the byte as it was before the write.
- R9: With `PROTECT_EN`=0, `wr_fault` is always 0 and every write reaches the array, whatever the mask holds.
- R10: Reads from a region whose mask bit is 0 still return the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Byte address (ignored for mask accesses) |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 8 | Write data for the array or the mask |
| reg_sel | input | 1 | 1 selects the mask register, 0 selects the array |
| priv | input | 1 | Privilege flag from the processor, required for mask writes |
| rd_data | output | 8 | Registered read data |
| wr_fault | output | 1 | Sticky write-violation flag |

## Verification
On every cycle, the assertions check the following:
- a blocked store, a granted store and a mask load never coincide;
- every rise of the fault follows a blocked store;
- the fault holds until a privileged mask load clears it;
- the mask changes only through such a load, and to the offered data;
- the fault stays low in the unprotected build.

The array contents can only be shown by the bench's scenarios. These cover bytes surviving a blocked store, read-before-write ordering, the exact region boundary, reads from locked regions, and the unprotected build storing what the protected one refused.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  // region index of an address: its top RGN_W bits
  function automatic int unsigned region_of(input int unsigned addr,
                                            input int unsigned addr_w,
                                            input int unsigned rgn_w);
    return addr >> (addr_w - rgn_w);
  endfunction

  // reset value of the mask: every region writable
  function automatic logic [31:0] mask_reset(input int unsigned nreg);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) if (i < nreg) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/wpr_mask_reg.sv
module wpr_mask_reg #(
  parameter int NREG   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [NREG-1:0]   mask_q
);
  import wpr_pkg::*;

  localparam logic [31:0] RST_WORD = mask_reset(NREG);
  localparam logic [NREG-1:0] RST_VAL = RST_WORD[NREG-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= RST_VAL;
    else if (load) mask_q <= din[NREG-1:0];
  end
endmodule

// File: rtl/wpr_wr_qual.sv
module wpr_wr_qual #(
  parameter int ADDR_W     = 10,
  parameter int NREG       = 8,
  parameter bit PROTECT_EN = 1'b1
) (
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic              priv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NREG-1:0]   mask_q,
  output logic              mem_we,
  output logic              blocked,
  output logic              mask_load
);
  import wpr_pkg::*;

  localparam int RGN_W = $clog2(NREG);

  logic data_wr;
  assign data_wr   = wr_en && !reg_sel;
  assign mask_load = wr_en && reg_sel && priv;

  generate
    if (PROTECT_EN) begin : g_prot
      logic [RGN_W-1:0] rgn;
      logic             allow;
      assign rgn     = RGN_W'(region_of(32'(addr), ADDR_W, RGN_W));
      assign allow   = mask_q[rgn];
      assign mem_we  = data_wr && allow;
      assign blocked = data_wr && !allow;
    end else begin : g_open
      assign mem_we  = data_wr;
      assign blocked = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wpr_fault_flag.sv
module wpr_fault_flag #(
  parameter bit PROTECT_EN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic fault
);
  generate
    if (PROTECT_EN) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (clr) flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
      end
      assign fault = flag_q;
    end else begin : g_none
      assign fault = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/wpr_mem_array.sv
module wpr_mem_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read returns the byte as it stood before this edge's write
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/wpram_top.sv
module wpram_top #(
  parameter int DATA_W     = 8,
  parameter int DEPTH      = 1024,
  parameter int NUM_RGN    = 8,
  parameter bit PROTECT_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic                     wr_en,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     reg_sel,
  input  logic                     priv,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     wr_fault
);
  localparam int ADDR_W = $clog2(DEPTH);

  // named internal events, observed by the bound checker
  logic [NUM_RGN-1:0] mask_q;
  logic               wr_grant;
  logic               wr_block;
  logic               mask_wr;
  logic [DATA_W-1:0]  mem_rd;
  logic [DATA_W-1:0]  mask_ext;
  logic [DATA_W-1:0]  mask_rd_q;
  logic               sel_q;

  wpr_mask_reg #(.NREG(NUM_RGN), .DATA_W(DATA_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_wr), .din(wr_data), .mask_q(mask_q)
  );

  wpr_wr_qual #(.ADDR_W(ADDR_W), .NREG(NUM_RGN), .PROTECT_EN(PROTECT_EN)) u_qual (
    .wr_en(wr_en), .reg_sel(reg_sel), .priv(priv), .addr(addr), .mask_q(mask_q),
    .mem_we(wr_grant), .blocked(wr_block), .mask_load(mask_wr)
  );

  wpr_fault_flag #(.PROTECT_EN(PROTECT_EN)) u_fault (
    .clk(clk), .rst_n(rst_n), .set(wr_block), .clr(mask_wr), .fault(wr_fault)
  );

  wpr_mem_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(wr_grant), .addr(addr), .wdata(wr_data), .rdata(mem_rd)
  );

  always_comb begin
    mask_ext = '0;
    mask_ext[NUM_RGN-1:0] = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      mask_rd_q <= '0;
    end else begin
      sel_q     <= reg_sel;
      mask_rd_q <= mask_ext;
    end
  end

  assign rd_data = sel_q ? mask_rd_q : mem_rd;
endmodule

// File: rtl/wpr_checks.sv
module wpr_checks #(
  parameter int NREG       = 8,
  parameter int DATA_W     = 8,
  parameter bit PROTECT_EN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              priv,
  input logic [DATA_W-1:0] wr_data,
  input logic [NREG-1:0]   mask_q,
  input logic              wr_grant,
  input logic              wr_block,
  input logic              mask_wr,
  input logic              wr_fault
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_grant, wr_block, mask_wr}));

  p_block_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> wr_fault);

  p_fault_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_fault) |-> $past(wr_block));

  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fault && !mask_wr) |=> wr_fault);

  p_fault_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> !wr_fault);

  p_mask_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |-> priv);

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wr_data[NREG-1:0])));

  generate
    if (!PROTECT_EN) begin : g_open_chk
      p_fault_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fault);
    end
  endgenerate
endmodule

bind wpram_top wpr_checks #(.NREG(NUM_RGN), .DATA_W(DATA_W), .PROTECT_EN(PROTECT_EN)) u_wpr_checks (
  .clk(clk), .rst_n(rst_n), .priv(priv), .wr_data(wr_data), .mask_q(mask_q),
  .wr_grant(wr_grant), .wr_block(wr_block), .mask_wr(mask_wr), .wr_fault(wr_fault)
);

// File: tb/wpram_top_bench.sv
module wpram_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       reg_sel = 1'b0;
  logic       priv = 1'b0;
  logic [7:0] rd_data, rd_data_nop;
  logic       wr_fault, wr_fault_nop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wpram_top u_wpram_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .reg_sel(reg_sel), .priv(priv), .rd_data(rd_data), .wr_fault(wr_fault)
  );

  wpram_top #(.PROTECT_EN(1'b0)) u_wpram_top_nop (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .reg_sel(reg_sel), .priv(priv), .rd_data(rd_data_nop), .wr_fault(wr_fault_nop)
  );

  // entry: {is_read, reg_sel, priv, addr[9:0], wr_data[7:0], exp_rd[7:0], exp_fault}
  localparam int NV = 18;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,10'h005,8'h11,8'h00,1'b0},  // R2 fill region 0
    {1'b0,1'b0,1'b0,10'h085,8'h22,8'h00,1'b0},  // fill region 1
    {1'b0,1'b0,1'b0,10'h3FF,8'h33,8'h00,1'b0},  // fill region 7
    {1'b1,1'b0,1'b0,10'h005,8'h00,8'h11,1'b0},  // R2
    {1'b1,1'b0,1'b0,10'h085,8'h00,8'h22,1'b0},  // R2
    {1'b1,1'b0,1'b0,10'h3FF,8'h00,8'h33,1'b0},  // R2
    {1'b0,1'b1,1'b1,10'h000,8'hFD,8'h00,1'b0},  // R7 lock region 1
    {1'b1,1'b1,1'b0,10'h000,8'h00,8'hFD,1'b0},  // R7 readback
    {1'b0,1'b0,1'b0,10'h085,8'h99,8'h00,1'b1},  // R4 blocked
    {1'b1,1'b0,1'b0,10'h085,8'h00,8'h22,1'b1},  // R4 unchanged, R10
    {1'b0,1'b0,1'b0,10'h005,8'h44,8'h00,1'b1},  // R5 sticky on good write
    {1'b1,1'b0,1'b0,10'h005,8'h00,8'h44,1'b1},  // R3 open region stored
    {1'b0,1'b1,1'b0,10'h000,8'h00,8'h00,1'b1},  // R6 unprivileged mask write
    {1'b1,1'b1,1'b0,10'h000,8'h00,8'hFD,1'b1},  // R6 mask unchanged
    {1'b0,1'b1,1'b1,10'h000,8'hFF,8'h00,1'b0},  // R5 cleared by priv mask write
    {1'b1,1'b1,1'b0,10'h000,8'h00,8'hFF,1'b0},  // R7
    {1'b0,1'b0,1'b0,10'h085,8'h55,8'h00,1'b0},  // R3 region 1 reopened
    {1'b1,1'b0,1'b0,10'h085,8'h00,8'h55,1'b0}   // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic op(input logic we, input logic sel, input logic pv,
                    input logic [9:0] a, input logic [7:0] d);
    wr_en = we; reg_sel = sel; priv = pv; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 fault after reset", {7'b0, wr_fault}, 8'h00);
    op(1'b0, 1'b1, 1'b0, 10'h000, 8'h00);
    chk("R1 mask after reset", rd_data, 8'hFF);

    // vector table
    for (int i = 0; i < NV; i++) begin
      op(~VEC[i][29], VEC[i][28], VEC[i][27], VEC[i][26:17], VEC[i][16:9]);
      if (VEC[i][29]) chk("R2/R7 table read", rd_data, VEC[i][8:1]);
      chk("R4/R5 table fault", {7'b0, wr_fault}, {7'b0, VEC[i][0]});
      chk("R9 table open fault", {7'b0, wr_fault_nop}, 8'h00);
    end

    // R8 read-before-write
    op(1'b1, 1'b0, 1'b0, 10'h005, 8'h66);
    chk("R8 old data on same-cycle write", rd_data, 8'h44);
    op(1'b0, 1'b0, 1'b0, 10'h005, 8'h00);
    chk("R8 new data after", rd_data, 8'h66);

    // R3 region boundary with only region 0 open
    op(1'b1, 1'b1, 1'b1, 10'h000, 8'h01);
    op(1'b1, 1'b0, 1'b0, 10'h07F, 8'h7A);
    chk("R3 last byte of region 0 writable", {7'b0, wr_fault}, 8'h00);
    op(1'b1, 1'b0, 1'b0, 10'h080, 8'hB0);
    chk("R3 first byte of region 1 blocked", {7'b0, wr_fault}, 8'h01);
    op(1'b0, 1'b0, 1'b0, 10'h07F, 8'h00);
    chk("R3 region 0 byte stored", rd_data, 8'h7A);

    // R10 reads from fully locked memory; R5 clear by privileged mask write
    op(1'b1, 1'b1, 1'b1, 10'h000, 8'h00);
    chk("R5 cleared by mask write", {7'b0, wr_fault}, 8'h00);
    op(1'b0, 1'b0, 1'b0, 10'h005, 8'h00);
    chk("R10 read from locked region", rd_data, 8'h66);

    // R9 unprotected build stores what the protected one refuses
    op(1'b1, 1'b0, 1'b0, 10'h200, 8'hA5);
    chk("R4 locked write faults", {7'b0, wr_fault}, 8'h01);
    chk("R9 open build no fault", {7'b0, wr_fault_nop}, 8'h00);
    op(1'b0, 1'b0, 1'b0, 10'h200, 8'h00);
    chk("R9 open build stored byte", rd_data_nop, 8'hA5);

    // R5 reset clears the fault; R1 mask back to all ones
    do_reset();
    chk("R5 fault cleared by reset", {7'b0, wr_fault}, 8'h00);
    op(1'b0, 1'b1, 1'b0, 10'h000, 8'h00);
    chk("R1 mask restored by reset", rd_data, 8'hFF);

    finish_run();
  end
endmodule